// File: doc/BRIEF.md
# External Bus Idle-Cycle Inserter

This block sits between an internal access requester and an external memory bus shared by several chip-select spaces. Before each new access starts, it decides how many empty bus cycles must go by. It takes that count from the previous access, the pending one and a small configuration register held for each supported space. While the gap runs, the bus stays parked with no chip select active. Once the gap is over and the bus is free, the pending request is granted.

Software programs the gap lengths through a simple register port, one 32-bit register for each supported space (IDs 0, 3 and 4). Each register holds two 2-bit codes. One applies after a write, whatever the next direction. The other applies when a read is followed by a write to a different space. Both codes map to 0, 1, 2 or 4 cycles. The registers are cleared only by the power-on reset. A soft reset leaves their contents alone and forgets only the access history.

Top module: `bus_gap_inserter`

## Requirements
- R1: Registers exist only for space IDs 0, 3 and 4. A write with `cfg_sel` equal to one of these updates that register. A write to any other ID changes nothing, and reading an unsupported ID returns 0. The read data follows `cfg_sel` combinationally.
- R2: Bits 29:28 hold the after-write code and bits 26:25 hold the read-to-write cross-space code. Every other bit reads 0, whatever was written.
- R3: Both codes map 00 to 0 idle cycles, 01 to 1, 10 to 2 and 11 to 4.
- R4: When the previous granted access was a write, the next access, read or write and to any space, waits for the after-write count of the previous access's space.
- R5: When the previous access was a read and the next is a write to a different space, the gap is the cross-space count of the previous space. Read then read, and read then write to the same space, insert no gap.
- R6: The first request after a power-on or soft reset gets no gap. It is granted in the cycle it appears if the bus is free.
- R7: A gap of N cycles keeps `req_grant` low and `gap_active` high for the N cycles starting with the one in which the request appears. The grant comes combinationally in cycle N. `req_grant` is never high without `req_valid`.
- R8: While `bus_busy` is high, no grant is given. The gap keeps counting during that time.
- R9: Power-on reset sets each supported register to 0x3600_0000, so both codes are 11. A soft reset keeps register contents.
- R10: A register write made while a gap is running does not change that gap. The new value applies from the next gap computation onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Synchronous power-on reset, active high; clears registers and history |
| rst_soft | input | 1 | Synchronous soft reset, active high; clears history and gap only |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Space ID of the register accessed |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_sel` |
| req_valid | input | 1 | Access pending; held until granted |
| req_space | input | 3 | Space ID of the pending access |
| req_write | input | 1 | 1 = write, 0 = read |
| bus_busy | input | 1 | External bus still occupied |
| req_grant | output | 1 | Pending access may start this cycle |
| gap_active | output | 1 | Idle gap running; bus parked, no chip select |

## Verification
The grant and `gap_active` depend combinationally on the request and on the registered counter. So the expected gap length is the number of falling edges seen between raising `req_valid` and the first sample with `req_grant` high, and a correct block makes that number equal to the decoded code. Each sample is taken 1 ns after a falling edge, when all registered state has settled. Register read data is combinational and is checked in the same low phase in which `cfg_sel` is driven. A write is first visible one clock edge after its strobe.

// File: rtl/bus_gap_pkg.sv
package bus_gap_pkg;

    localparam int SPACE_W    = 3;
    localparam int NUM_SPACES = 3;
    localparam int REG_W      = 32;
    localparam int CODE_W     = 2;
    localparam int CNT_W      = 3;
    localparam int WR_LSB     = 28;
    localparam int XRW_LSB    = 25;

    localparam logic [REG_W-1:0] FIELD_MASK = 32'h3600_0000;
    localparam logic [REG_W-1:0] POR_VALUE  = 32'h3600_0000;
    localparam logic [CODE_W-1:0] POR_CODE  = 2'b11;

    typedef logic [CODE_W-1:0]  gap_code_t;
    typedef logic [CNT_W-1:0]   gap_cnt_t;
    typedef logic [SPACE_W-1:0] space_id_t;

    typedef struct packed {
        gap_code_t after_wr;
        gap_code_t cross_rw;
    } gap_cfg_t;

    typedef struct packed {
        logic      valid;
        space_id_t space;
        logic      write;
    } acc_rec_t;

    function automatic space_id_t slot_to_id(input int slot);
        case (slot)
            0:       return space_id_t'(0);
            1:       return space_id_t'(3);
            default: return space_id_t'(4);
        endcase
    endfunction

    function automatic gap_cnt_t code_to_cycles(input gap_code_t code);
        return (code == 2'b11) ? gap_cnt_t'(4) : gap_cnt_t'(code);
    endfunction

endpackage

// File: rtl/bus_gap_space_reg.sv
module bus_gap_space_reg
    import bus_gap_pkg::*;
#(
    parameter space_id_t SPACE_ID = '0
) (
    input  logic              clk,
    input  logic              rst_por,
    input  logic              cfg_wr,
    input  space_id_t         cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output gap_cfg_t          cfg_out,
    output logic [REG_W-1:0]  rdata
);
    logic     hit;
    gap_cfg_t cfg_q;

    assign hit = (cfg_sel == SPACE_ID);

    always_ff @(posedge clk) begin
        if (rst_por) begin
            cfg_q.after_wr <= POR_CODE;
            cfg_q.cross_rw <= POR_CODE;
        end else if (cfg_wr && hit) begin
            cfg_q.after_wr <= cfg_wdata[WR_LSB +: CODE_W];
            cfg_q.cross_rw <= cfg_wdata[XRW_LSB +: CODE_W];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[WR_LSB +: CODE_W]  = cfg_q.after_wr;
            rdata[XRW_LSB +: CODE_W] = cfg_q.cross_rw;
        end
    end

    assign cfg_out = cfg_q;

endmodule

// File: rtl/bus_gap_calc.sv
module bus_gap_calc
    import bus_gap_pkg::*;
(
    input  acc_rec_t  hist,
    input  gap_cfg_t  prev_cfg,
    input  space_id_t nxt_space,
    input  logic      nxt_write,
    output gap_cnt_t  gap_cycles
);
    always_comb begin
        if (!hist.valid) begin
            gap_cycles = '0;
        end else if (hist.write) begin
            gap_cycles = code_to_cycles(prev_cfg.after_wr);
        end else if (nxt_write && (nxt_space != hist.space)) begin
            gap_cycles = code_to_cycles(prev_cfg.cross_rw);
        end else begin
            gap_cycles = '0;
        end
    end
endmodule

// File: rtl/bus_gap_timer.sv
module bus_gap_timer
    import bus_gap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  logic     bus_busy,
    input  gap_cnt_t gap_cycles,
    output logic     grant,
    output logic     gap_active
);
    logic     loaded;
    gap_cnt_t cnt;
    logic     fresh;
    logic     expired;

    assign fresh      = req_valid && !loaded;
    assign expired    = fresh ? (gap_cycles == '0) : (cnt == '0);
    assign gap_active = req_valid && !expired;
    assign grant      = req_valid && expired && !bus_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            loaded <= 1'b0;
            cnt    <= '0;
        end else if (grant) begin
            loaded <= 1'b0;
            cnt    <= '0;
        end else if (fresh) begin
            loaded <= 1'b1;
            cnt    <= (gap_cycles == '0) ? gap_cnt_t'(0) : gap_cycles - gap_cnt_t'(1);
        end else if (loaded && cnt != '0) begin
            cnt    <= cnt - gap_cnt_t'(1);
        end
    end

    AST_GAP_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (loaded && cnt != '0 && req_valid) |=> (cnt == $past(cnt) - gap_cnt_t'(1))); // R7

    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        grant |-> req_valid); // R7

endmodule

// File: rtl/bus_gap_inserter.sv
module bus_gap_inserter
    import bus_gap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_por,
    input  logic              rst_soft,
    input  logic              cfg_wr,
    input  logic [SPACE_W-1:0] cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    input  logic [SPACE_W-1:0] req_space,
    input  logic              req_write,
    input  logic              bus_busy,
    output logic              req_grant,
    output logic              gap_active
);
    logic              hist_rst;
    gap_cfg_t          cfg_arr   [NUM_SPACES];
    logic [REG_W-1:0]  rdata_arr [NUM_SPACES];
    acc_rec_t          hist;
    gap_cfg_t          prev_cfg;
    gap_cnt_t          gap_cycles;

    assign hist_rst = rst_por || rst_soft;

    for (genvar g = 0; g < NUM_SPACES; g++) begin : g_space
        bus_gap_space_reg #(.SPACE_ID(slot_to_id(g))) u_reg (
            .clk       (clk),
            .rst_por   (rst_por),
            .cfg_wr    (cfg_wr),
            .cfg_sel   (cfg_sel),
            .cfg_wdata (cfg_wdata),
            .cfg_out   (cfg_arr[g]),
            .rdata     (rdata_arr[g])
        );

        AST_SOFT_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst_por)
            (rst_soft && !cfg_wr) |=> $stable(cfg_arr[g])); // R9
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_SPACES; i++) begin
            cfg_rdata = cfg_rdata | rdata_arr[i];
        end
    end

    always_comb begin
        prev_cfg = '0;
        for (int i = 0; i < NUM_SPACES; i++) begin
            if (hist.space == slot_to_id(i)) begin
                prev_cfg = cfg_arr[i];
            end
        end
    end

    bus_gap_calc u_calc (
        .hist       (hist),
        .prev_cfg   (prev_cfg),
        .nxt_space  (req_space),
        .nxt_write  (req_write),
        .gap_cycles (gap_cycles)
    );

    bus_gap_timer u_timer (
        .clk        (clk),
        .rst        (hist_rst),
        .req_valid  (req_valid),
        .bus_busy   (bus_busy),
        .gap_cycles (gap_cycles),
        .grant      (req_grant),
        .gap_active (gap_active)
    );

    always_ff @(posedge clk) begin
        if (hist_rst) begin
            hist <= '0;
        end else if (req_grant) begin
            hist.valid <= 1'b1;
            hist.space <= req_space;
            hist.write <= req_write;
        end
    end

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst_por)
        (cfg_rdata & ~FIELD_MASK) == '0); // R2

    AST_FIRST_FREE: assert property (@(posedge clk) disable iff (hist_rst)
        (req_valid && !hist.valid) |-> !gap_active); // R6

    AST_GRANT_NO_GAP: assert property (@(posedge clk) disable iff (hist_rst)
        req_grant |-> !gap_active); // R7

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (hist_rst)
        (req_valid && bus_busy) |-> !req_grant); // R8

endmodule

// File: tb/bus_gap_inserter_bench.sv
module bus_gap_inserter_bench;
    logic        clk = 1'b0;
    logic        rst_por = 1'b1;
    logic        rst_soft = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [2:0]  req_space = '0;
    logic        req_write = 1'b0;
    logic        bus_busy = 1'b0;
    logic        req_grant;
    logic        gap_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bus_gap_inserter u_bus_gap_inserter (
        .clk(clk), .rst_por(rst_por), .rst_soft(rst_soft),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_space(req_space), .req_write(req_write),
        .bus_busy(bus_busy), .req_grant(req_grant), .gap_active(gap_active)
    );

    // vector: {space[2:0], write, expected gap[3:0]}, power-on register values
    localparam logic [7:0] VEC [8] = '{
        {3'd0, 1'b0, 4'd0},   // R6 first access free
        {3'd0, 1'b0, 4'd0},   // R5 read-read
        {3'd0, 1'b1, 4'd0},   // R5 read-write same space
        {3'd3, 1'b0, 4'd4},   // R4 write-read, code 11
        {3'd4, 1'b1, 4'd4},   // R5 read-write across spaces
        {3'd4, 1'b1, 4'd4},   // R4 write-write
        {3'd4, 1'b0, 4'd4},   // R4 write-read same space
        {3'd4, 1'b1, 4'd0}    // R5 read-write same space
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input string req, input logic [2:0] sel, input logic [31:0] exp);
        cfg_sel = sel;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic access(input string req, input logic [2:0] sp, input logic wr,
                          input int exp, input bit midwr);
        int n = 0;
        int act = 0;
        req_space = sp; req_write = wr; req_valid = 1'b1;
        #1;
        while (!req_grant && n < 40) begin
            if (gap_active) act++;
            if (midwr && n == 1) begin
                cfg_wr = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h0;
            end
            @(negedge clk); #1;
            cfg_wr = 1'b0;
            n++;
        end
        check({req, " gap length"}, n, exp);
        check({req, " gap_active cycles"}, act, exp);
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rst_por = 1'b0;
        // R9 power-on values, R1 unsupported IDs read zero
        cfg_read("R9 por value space0", 3'd0, 32'h3600_0000);
        cfg_read("R9 por value space3", 3'd3, 32'h3600_0000);
        cfg_read("R9 por value space4", 3'd4, 32'h3600_0000);
        cfg_read("R1 unsupported id reads 0", 3'd1, 32'h0);
        check("R7 no grant without request", req_grant, 1'b0);

        for (int i = 0; i < 8; i++) begin
            access($sformatf("R4/R5 vector %0d", i), VEC[i][7:5], VEC[i][4], int'(VEC[i][3:0]), 1'b0);
        end

        // R2 reserved bits ignored; R3 codes 01,10,00,01
        cfg_write(3'd0, 32'hDDFF_FFFF);
        cfg_read("R2 reserved bits read 0", 3'd0, 32'h1400_0000);
        cfg_write(3'd3, 32'h2000_0000);
        cfg_write(3'd4, 32'h0200_0000);
        cfg_write(3'd2, 32'hFFFF_FFFF);
        cfg_read("R1 write to unsupported id ignored", 3'd2, 32'h0);
        cfg_read("R1 other register untouched", 3'd4, 32'h0200_0000);

        access("R3 R4 code 00", 3'd0, 1'b0, 0, 1'b0);
        access("R3 R5 code 10", 3'd3, 1'b1, 2, 1'b0);
        access("R3 R4 code 10", 3'd3, 1'b0, 2, 1'b0);
        access("R3 R5 code 00", 3'd4, 1'b1, 0, 1'b0);
        access("R3 R4 code 00 w-r", 3'd4, 1'b0, 0, 1'b0);
        access("R3 R5 code 01", 3'd0, 1'b1, 1, 1'b0);
        access("R3 R4 code 01", 3'd0, 1'b1, 1, 1'b0);

        // R9 soft reset keeps registers, R6 clears history
        rst_soft = 1'b1;
        @(negedge clk); #1;
        rst_soft = 1'b0;
        cfg_read("R9 soft reset keeps space0", 3'd0, 32'h1400_0000);
        cfg_read("R9 soft reset keeps space3", 3'd3, 32'h2000_0000);
        access("R6 first after soft reset", 3'd3, 1'b0, 0, 1'b0);

        // R10 write during a running gap
        cfg_write(3'd0, 32'h3000_0000);
        access("R10 setup", 3'd0, 1'b1, 0, 1'b0);
        access("R10 gap kept during write", 3'd0, 1'b0, 4, 1'b1);
        cfg_read("R10 write landed", 3'd0, 32'h0);
        access("R10 setup write", 3'd0, 1'b1, 0, 1'b0);
        access("R10 new value used next", 3'd3, 1'b0, 0, 1'b0);

        // R8 bus busy holds grant
        bus_busy = 1'b1;
        req_space = 3'd3; req_write = 1'b0; req_valid = 1'b1;
        #1;
        for (int k = 0; k < 3; k++) begin
            check("R8 no grant while busy", req_grant, 1'b0);
            @(negedge clk); #1;
        end
        bus_busy = 1'b0;
        #1;
        check("R8 grant after busy clears", req_grant, 1'b1);
        @(negedge clk); #1;
        req_valid = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule